// File: doc/BRIEF.md
# BLDC Commutation Encoder with Direction-Controlled Phase Advance

This block turns a measured mechanical rotor angle into the three block-commutation phase signals that drive a brushless motor. The angle first receives a fixed zero correction. It then receives a phase advance built from two parts: a small static step chosen by a 2-bit code, and a dynamic amount that is written while the block runs. The adjusted angle is scaled by the selected number of pole pairs into an electrical angle. That electrical angle is split into six 60-degree sectors, and each sector has its own U/V/W pattern.

A direction input decides whether the advance is added to the angle (clockwise) or subtracted from it (counter-clockwise). Each time the direction changes, the dynamic advance is discarded, so a new value has to be written after a reversal. The direction input is synchronised before it is used. When the angle source reports that it is not locked, all three phases are held low.

Top module: `phase_commutator`

## Requirements
- R1: The zero angle (0..359) is added to the measured angle (0..359), and the sum wraps modulo 360.
- R2: Pole code 0..5 selects 1..6 pole pairs. Codes 6 and 7 also select 6 pole pairs.
- R3: The static advance code selects 0 mechanical degrees for code 0, 2 for code 1, 4 for code 2 and 8 for code 3.
- R4: A pulse on adv_dyn_wr loads adv_dyn_data (0..63 mechanical degrees) as the dynamic advance. The register changes only on such a write or when it is cleared.
- R5: With dir_in=0 the sum of the static and dynamic advances is added to the corrected angle. With dir_in=1 that sum is subtracted. Results wrap into the range 0..359.
- R6: Any change of dir_in clears the dynamic advance to 0. The clear happens in the same cycle that the new direction is applied.
- R7: A change of dir_in first shows on the phases at the third rising edge after the change. The first and second edges still show the old direction.
- R8: The electrical angle is (adjusted angle × pole pairs) mod 360. Sector = electrical angle / 60. Sectors 0..5 drive {U,V,W} = 100, 110, 010, 011, 001, 101. A change of the angle shows on the phases after one rising edge.
- R9: While angle_valid is 0, all three phases are 0 from the next rising edge onward.
- R10: During synchronous reset the phases are 0, the dynamic advance is 0 and the synchronised direction is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mech_angle | input | 9 | Measured mechanical angle, 0..359 |
| angle_valid | input | 1 | Angle source locked |
| zero_angle | input | 9 | Zero correction, 0..359 |
| pole_code | input | 3 | Pole-pair selection code |
| adv_static_code | input | 2 | Static advance code |
| adv_dyn_data | input | 6 | Dynamic advance value for a write |
| adv_dyn_wr | input | 1 | Write strobe for the dynamic advance |
| dir_in | input | 1 | Rotation direction, 0 = clockwise |
| phase_u | output | 1 | Phase U |
| phase_v | output | 1 | Phase V |
| phase_w | output | 1 | Phase W |

## Verification
The assertions check four properties on every cycle:
- the phases go to zero whenever the angle is not locked;
- while the angle is locked, the phases never show 000 or 111;
- the adjusted angle stays below 360 for inputs in range;
- the dynamic advance is zero whenever the applied direction has just changed, and it moves only through a write or a clear.

The actual sector values need the bench's scenarios. These cover the zero wrap, the saturation of the pole code, the weight of each static code, addition versus subtraction with wrap below zero, and the exact edge on which a reversal reaches the phases.

// File: rtl/commut_pkg.sv
package commut_pkg;

    localparam int ANG_W      = 9;
    localparam int FULL_TURN  = 360;
    localparam int SECTOR_DEG = 60;
    localparam int N_SECTORS  = 6;
    localparam int DYN_W      = 6;
    localparam int POLE_W     = 3;
    localparam int MAX_POLES  = 6;

    typedef logic [ANG_W-1:0] angle_t;

    typedef struct packed {
        logic u;
        logic v;
        logic w;
    } phase_t;

    typedef enum logic [1:0] {
        ADV_NONE = 2'd0,
        ADV_TWO  = 2'd1,
        ADV_FOUR = 2'd2,
        ADV_EIGHT = 2'd3
    } adv_code_e;

    function automatic logic [3:0] static_deg(input logic [1:0] code);
        case (adv_code_e'(code))
            ADV_NONE:  return 4'd0;
            ADV_TWO:   return 4'd2;
            ADV_FOUR:  return 4'd4;
            default:   return 4'd8;
        endcase
    endfunction

    function automatic logic [POLE_W-1:0] pole_pairs(input logic [POLE_W-1:0] code);
        if (code >= POLE_W'(MAX_POLES - 1))
            return POLE_W'(MAX_POLES);
        else
            return code + POLE_W'(1);
    endfunction

    function automatic phase_t sector_phase(input logic [2:0] sec);
        case (sec)
            3'd0:    return '{u: 1'b1, v: 1'b0, w: 1'b0};
            3'd1:    return '{u: 1'b1, v: 1'b1, w: 1'b0};
            3'd2:    return '{u: 1'b0, v: 1'b1, w: 1'b0};
            3'd3:    return '{u: 1'b0, v: 1'b1, w: 1'b1};
            3'd4:    return '{u: 1'b0, v: 1'b0, w: 1'b1};
            default: return '{u: 1'b1, v: 1'b0, w: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/dir_tracker.sv
module dir_tracker
    import commut_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = DYN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_in,
    input  logic          dyn_wr,
    input  logic [DW-1:0] dyn_data,
    output logic          dir_eff,
    output logic [DW-1:0] dyn_val
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [DW-1:0]          dyn_q;
    logic                   dir_chg;

    // synchroniser chain, one flop per stage
    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= dir_in;
    end

    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
        end
    end

    assign dir_chg = sync_q[LAST] ^ sync_q[LAST-1];

    // dynamic advance register: a reversal clears it, even over a write
    always_ff @(posedge clk) begin
        if (rst)          dyn_q <= '0;
        else if (dir_chg) dyn_q <= '0;
        else if (dyn_wr)  dyn_q <= dyn_data;
    end

    assign dir_eff = sync_q[LAST];
    assign dyn_val = dyn_q;

    // R4
    dyn_source_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dyn_q) |-> (dyn_q == '0 || $past(dyn_wr)));

endmodule

// File: rtl/angle_offset.sv
module angle_offset
    import commut_pkg::*;
#(
    parameter int AW = ANG_W,
    parameter int DW = DYN_W
) (
    input  logic [AW-1:0] raw_ang,
    input  logic [AW-1:0] zero_ang,
    input  logic [1:0]    stat_code,
    input  logic [DW-1:0] dyn_val,
    input  logic          dir_ccw,
    output logic [AW-1:0] adj_ang
);

    localparam int SW = AW + 1;
    localparam logic [SW-1:0] TURN = SW'(FULL_TURN);

    logic [SW-1:0] base_sum, base, adv, fwd, rev;

    always_comb begin
        base_sum = SW'(raw_ang) + SW'(zero_ang);
        base     = (base_sum >= TURN) ? base_sum - TURN : base_sum;
        adv      = SW'(static_deg(stat_code)) + SW'(dyn_val);
        fwd      = base + adv;
        if (fwd >= TURN) fwd = fwd - TURN;
        rev      = (base >= adv) ? base - adv : base + TURN - adv;
        adj_ang  = dir_ccw ? rev[AW-1:0] : fwd[AW-1:0];
    end

endmodule

// File: rtl/sector_map.sv
module sector_map
    import commut_pkg::*;
#(
    parameter int AW = ANG_W
) (
    input  logic [AW-1:0]     adj_ang,
    input  logic [POLE_W-1:0] pole_code,
    output phase_t            phase
);

    localparam int EW = AW + POLE_W;
    localparam logic [EW-1:0] SEC_W  = EW'(SECTOR_DEG);
    localparam logic [EW-1:0] NSEC_W = EW'(N_SECTORS);

    logic [EW-1:0] elec_full;
    logic [EW-1:0] sec_full;

    always_comb begin
        elec_full = EW'(adj_ang) * EW'(pole_pairs(pole_code));
        sec_full  = (elec_full / SEC_W) % NSEC_W;
        phase     = sector_phase(sec_full[2:0]);
    end

endmodule

// File: rtl/phase_commutator.sv
module phase_commutator
    import commut_pkg::*;
#(
    parameter int AW          = ANG_W,
    parameter int DW          = DYN_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     mech_angle,
    input  logic              angle_valid,
    input  logic [AW-1:0]     zero_angle,
    input  logic [POLE_W-1:0] pole_code,
    input  logic [1:0]        adv_static_code,
    input  logic [DW-1:0]     adv_dyn_data,
    input  logic              adv_dyn_wr,
    input  logic              dir_in,
    output logic              phase_u,
    output logic              phase_v,
    output logic              phase_w
);

    logic          dir_eff;
    logic [DW-1:0] dyn_val;
    logic [AW-1:0] adj_ang;
    phase_t        phase_nxt, phase_q;

    dir_tracker #(.SYNC_STAGES(SYNC_STAGES), .DW(DW)) dir_i (
        .clk      (clk),
        .rst      (rst),
        .dir_in   (dir_in),
        .dyn_wr   (adv_dyn_wr),
        .dyn_data (adv_dyn_data),
        .dir_eff  (dir_eff),
        .dyn_val  (dyn_val)
    );

    angle_offset #(.AW(AW), .DW(DW)) ofs_i (
        .raw_ang   (mech_angle),
        .zero_ang  (zero_angle),
        .stat_code (adv_static_code),
        .dyn_val   (dyn_val),
        .dir_ccw   (dir_eff),
        .adj_ang   (adj_ang)
    );

    sector_map #(.AW(AW)) sec_i (
        .adj_ang   (adj_ang),
        .pole_code (pole_code),
        .phase     (phase_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)               phase_q <= '0;
        else if (!angle_valid) phase_q <= '0;
        else                   phase_q <= phase_nxt;
    end

    assign phase_u = phase_q.u;
    assign phase_v = phase_q.v;
    assign phase_w = phase_q.w;

    // R9
    unlock_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !angle_valid |=> ({phase_u, phase_v, phase_w} == 3'b000));

    // R8
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        angle_valid |=> ({phase_u, phase_v, phase_w} != 3'b000 &&
                         {phase_u, phase_v, phase_w} != 3'b111));

    // R6
    dyn_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dir_eff) |-> (dyn_val == '0));

    // R5
    adj_range_chk: assert property (@(posedge clk) disable iff (rst)
        (mech_angle < AW'(FULL_TURN) && zero_angle < AW'(FULL_TURN))
        |-> (adj_ang < AW'(FULL_TURN)));

endmodule

// File: tb/phase_commutator_tb_top.sv
`timescale 1ns/1ps
module phase_commutator_tb_top;

    typedef struct {
        logic [2:0] exp;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] mech_angle = '0;
    logic       angle_valid = 1'b0;
    logic [8:0] zero_angle = '0;
    logic [2:0] pole_code = '0;
    logic [1:0] adv_static_code = '0;
    logic [5:0] adv_dyn_data = '0;
    logic       adv_dyn_wr = 1'b0;
    logic       dir_in = 1'b0;
    logic       phase_u, phase_v, phase_w;

    int checks = 0;
    int fails  = 0;
    int tb_dyn = 0;
    bit done   = 1'b0;
    item_t sb_q[$];

    always #2 clk = ~clk;

    phase_commutator dut_i (
        .clk(clk), .rst(rst), .mech_angle(mech_angle), .angle_valid(angle_valid),
        .zero_angle(zero_angle), .pole_code(pole_code),
        .adv_static_code(adv_static_code), .adv_dyn_data(adv_dyn_data),
        .adv_dyn_wr(adv_dyn_wr), .dir_in(dir_in),
        .phase_u(phase_u), .phase_v(phase_v), .phase_w(phase_w)
    );

    function automatic logic [2:0] ref_uvw(int ang, int zr, int pc, int sc, int dy,
                                           int d, int lk);
        int pp, sd, a, e;
        if (lk == 0) return 3'b000;
        pp = (pc > 5) ? 6 : pc + 1;
        sd = (sc == 0) ? 0 : (sc == 1) ? 2 : (sc == 2) ? 4 : 8;
        a  = (ang + zr) % 360;
        a  = (d != 0) ? (a - sd - dy + 720) % 360 : (a + sd + dy) % 360;
        e  = (a * pp) % 360;
        case (e / 60)
            0: return 3'b100;
            1: return 3'b110;
            2: return 3'b010;
            3: return 3'b011;
            4: return 3'b001;
            default: return 3'b101;
        endcase
    endfunction

    function automatic logic [2:0] model_now();
        return ref_uvw(int'(mech_angle), int'(zero_angle), int'(pole_code),
                       int'(adv_static_code), tb_dyn, int'(dir_in), int'(angle_valid));
    endfunction

    task automatic push(logic [2:0] e, string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // driver: apply a stimulus, let it settle, queue the expectation
    task automatic stim(int ang, int zr, int pc, int sc, int lk, string tag);
        @(negedge clk);
        mech_angle = 9'(ang); zero_angle = 9'(zr); pole_code = 3'(pc);
        adv_static_code = 2'(sc); angle_valid = lk[0];
        repeat (3) @(posedge clk);
        #1 push(model_now(), tag);
    endtask

    task automatic write_dyn(int v);
        @(negedge clk);
        adv_dyn_data = 6'(v); adv_dyn_wr = 1'b1;
        @(negedge clk);
        adv_dyn_wr = 1'b0;
        tb_dyn = v;
    endtask

    task automatic flip_dir_settle();
        @(negedge clk);
        dir_in = ~dir_in;
        tb_dyn = 0;
        repeat (4) @(posedge clk);
    endtask

    // monitor: compare against the scoreboard away from the active edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if ({phase_u, phase_v, phase_w} !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", it.tag,
                             {phase_u, phase_v, phase_w}, it.exp);
                end
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0] old_e;
        repeat (3) @(posedge clk);
        #1 push(3'b000, "R10 reset phases low");
        @(negedge clk);
        rst = 1'b0;

        // R8 six sectors with one pole pair
        for (int s = 0; s < 6; s++) stim(s * 60 + 5, 0, 0, 0, 1, "R8 sector walk");
        stim(0, 0, 0, 0, 1, "R8 sector 0 is 100");
        @(posedge clk); #1 push(3'b100, "R8 explicit code 100");

        // R1 zero correction with wrap
        stim(350, 20, 0, 0, 1, "R1 zero wrap 350+20");
        stim(100, 200, 0, 0, 1, "R1 zero 100+200");
        stim(359, 359, 0, 0, 1, "R1 zero wrap 359+359");

        // R2 pole pairs and saturation
        stim(35, 0, 1, 0, 1, "R2 two pole pairs");
        stim(50, 0, 5, 0, 1, "R2 code 5 six pairs");
        stim(50, 0, 7, 0, 1, "R2 code 7 saturates");
        stim(10, 0, 6, 0, 1, "R2 code 6 saturates");
        stim(100, 0, 3, 0, 1, "R2 four pole pairs");

        // R3 static advance weights
        stim(55, 0, 0, 3, 1, "R3 static 8 deg");
        stim(58, 0, 0, 1, 1, "R3 static 2 deg");
        stim(55, 0, 0, 2, 1, "R3 static 4 deg");
        stim(57, 0, 0, 2, 1, "R3 static 4 deg edge");

        // R4 dynamic advance write
        write_dyn(63);
        stim(0, 0, 0, 0, 1, "R4 dynamic 63 added");
        write_dyn(0);
        stim(0, 0, 0, 0, 1, "R4 dynamic 0 added");

        // R6 reversal clears the dynamic advance
        write_dyn(63);
        flip_dir_settle();
        stim(0, 0, 0, 0, 1, "R6 dynamic cleared on reversal");

        // R5 subtraction with wrap under zero
        write_dyn(10);
        stim(5, 0, 0, 0, 1, "R5 subtract wraps");
        stim(70, 0, 0, 3, 1, "R5 subtract static and dynamic");
        flip_dir_settle();
        write_dyn(10);
        stim(355, 0, 0, 3, 1, "R5 add wraps past 360");

        // R7 reversal latency: old on edges one and two, new on edge three
        write_dyn(4);
        stim(5, 0, 0, 3, 1, "R7 setup");
        old_e = model_now();
        @(negedge clk);
        dir_in = 1'b1;
        @(posedge clk); #1 push(old_e, "R7 edge one keeps old direction");
        @(posedge clk); #1 push(old_e, "R7 edge two keeps old direction");
        tb_dyn = 0;
        @(posedge clk); #1 push(model_now(), "R7 edge three applies new direction");
        @(negedge clk);

        // R9 unlock forces zero after one edge
        stim(200, 0, 1, 1, 1, "R9 locked before drop");
        @(negedge clk);
        angle_valid = 1'b0;
        @(posedge clk); #1 push(3'b000, "R9 unlocked phases low");
        stim(200, 0, 1, 1, 0, "R9 unlocked steady");

        repeat (3) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule